// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of an SDRAM interface and takes the device into and out of its two low-power modes: self-refresh and power-down. A power manager sends one-cycle request strobes. The block checks the entry conditions, then drives the clock-enable line and the four command pins through a fixed sequence. It holds clock-enable low for as long as the mode lasts. On the way out it inserts NOP cycles until the device may accept normal commands again.

Self-refresh is entered only when the bank tracker reports every bank closed. A request that arrives while any bank is open is held until the banks close. Leaving self-refresh costs the row cycle time plus the self-refresh exit time. When the refresh scheduler runs refreshes in bursts, the block asks it for a refresh burst at the end of that wait.

Power-down keeps no data refreshed, so the block limits how long it lasts. It leaves power-down when a wake strobe arrives, when the refresh scheduler raises refresh-due, or when a cycle limit expires. After a forced exit it hands control back to the refresh scheduler with a one-cycle request. While the block is idle it drives NOP and reports ready.

Top module: `sdram_lp_seq`

## Requirements
- R1: During and right after reset the block is idle: ready=1, cke=1, the command pins show NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), and rfsh_req=0.
- R2: In idle, sr_req with banks_idle=1 gives, on the next cycle, exactly one cycle of the self-refresh command ({cs_n,ras_n,cas_n,we_n}=4'b0001) with cke=0 and ready=0.
- R3: An sr_req seen while banks_idle=0 is held pending. While it is pending, ready stays 1, cke stays 1 and pd_req is ignored. The self-refresh command appears on the cycle after banks_idle is first sampled high.
- R4: After the self-refresh command, cke stays low with NOP on the pins until wake_req is sampled. While that lasts, sr_req, pd_req and refresh_due have no effect.
- R5: A wake_req during self-refresh raises cke on the next cycle. Only NOP is driven for T_RC+T_XSR cycles, and ready returns on the cycle after that.
- R6: With BURST_REFRESH=1, rfsh_req pulses for exactly one cycle: the last cycle of the self-refresh exit wait. With BURST_REFRESH=0 it never pulses after self-refresh.
- R7: In idle, pd_req with no pending self-refresh and refresh_due=0 gives cke=0, NOP and ready=0 on the next cycle. When refresh_due=1, pd_req is ignored.
- R8: Power-down keeps cke low for at most PD_MAX cycles. wake_req or refresh_due sampled during power-down ends it after the cycle in which it was sampled.
- R9: Leaving power-down raises cke together with a NOP on the next edge. Only NOP is driven for T_PDX cycles, and ready returns on the cycle after that.
- R10: A power-down exit forced by refresh_due or by the PD_MAX limit pulses rfsh_req in the last cycle of the exit wait. An exit caused only by wake_req does not pulse it.
- R11: ready is 1 only in idle. A wake_req in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Strobe requesting self-refresh |
| pd_req | input | 1 | Strobe requesting power-down |
| wake_req | input | 1 | Strobe requesting exit from the current low-power mode |
| banks_idle | input | 1 | All banks precharged, from the bank tracker |
| refresh_due | input | 1 | Refresh deadline approaching, from the refresh scheduler |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | High when normal commands may be issued |
| rfsh_req | output | 1 | One-cycle request for a refresh burst |

## Verification
A sequencer stuck in a hold state shows up as cke staying low past the wake cycle or past PD_MAX cycles. This is caught within one cycle of the expected rise. An exit-wait counter that is off by one moves the return of ready, and with it the rfsh_req pulse, by one cycle. The bench compares every pin on every cycle, so that shift is reported in the first cycle it occurs. A lost pending request or a wrong entry guard shows up either as a self-refresh command while banks are open or as ready staying high when the command is due. Sweeps over hold lengths, bank-busy delays and exit causes cover each of these paths.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE         = 3'd0,
      ST_SR_ENTER     = 3'd1,
      ST_SR_HOLD      = 3'd2,
      ST_SR_EXIT_WAIT = 3'd3,
      ST_PD_HOLD      = 3'd4,
      ST_PD_EXIT_WAIT = 3'd5
   } lp_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP  = 4'b0111;
   localparam sd_cmd_t CMD_SREF = 4'b0001;

endpackage

// File: rtl/lp_down_timer.sv
module lp_down_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lp_pd_watchdog.sv
module lp_pd_watchdog #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int WW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [WW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt_q <= '0;
      else if (!expire)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && (cnt_q == WW'(LIMIT - 1));

   // R8
   pd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) < LIMIT));

   // R8
   pd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/lp_pin_drive.sv
module lp_pin_drive
   import lp_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  lp_state_t state,
   output logic      cke,
   output sd_cmd_t   cmd,
   output logic      ready
);
   always_comb begin
      cmd   = CMD_NOP;
      cke   = 1'b1;
      ready = 1'b0;
      unique case (state)
         ST_IDLE:         ready = 1'b1;
         ST_SR_ENTER: begin
            cke = 1'b0;
            cmd = CMD_SREF;
         end
         ST_SR_HOLD:      cke = 1'b0;
         ST_PD_HOLD:      cke = 1'b0;
         ST_SR_EXIT_WAIT: cke = 1'b1;
         ST_PD_EXIT_WAIT: cke = 1'b1;
         default:         cke = 1'b1;
      endcase
   end

   // R2
   sref_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SREF) |-> !cke);

   // R9
   wake_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (cmd == CMD_NOP && !ready));

   // R11
   ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cke && cmd == CMD_NOP));

   // R4
   hold_after_sref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SREF) |=> (!cke && cmd == CMD_NOP));

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
   import lp_seq_pkg::*;
#(
   parameter int T_RC          = 8,
   parameter int T_XSR         = 10,
   parameter int T_PDX         = 2,
   parameter int PD_MAX        = 1000,
   parameter bit BURST_REFRESH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sr_req,
   input  logic pd_req,
   input  logic wake_req,
   input  logic banks_idle,
   input  logic refresh_due,
   output logic cke,
   output logic cs_n,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic ready,
   output logic rfsh_req
);
   localparam int SRX  = T_RC + T_XSR;
   localparam int MAXW = (SRX > T_PDX) ? SRX : T_PDX;
   localparam int TW   = $clog2(MAXW + 1);

   generate
      if (T_RC < 1) begin : g_bad_trc
         $error("T_RC must be at least 1");
      end
      if (T_XSR < 0) begin : g_bad_txsr
         $error("T_XSR must not be negative");
      end
      if (T_PDX < 1) begin : g_bad_tpdx
         $error("T_PDX must be at least 1");
      end
      if (PD_MAX < 2) begin : g_bad_pdmax
         $error("PD_MAX must be at least 2");
      end
   endgenerate

   lp_state_t state_q, state_d;
   logic      sr_pend_q;
   logic      pd_forced_q;
   logic      tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic      wd_expire;
   logic      pd_leave;
   logic      sr_kick, pd_kick;
   sd_cmd_t   cmd;

   assign pd_leave = wake_req || refresh_due || wd_expire;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if ((sr_req || sr_pend_q) && banks_idle)
               state_d = ST_SR_ENTER;
            else if (pd_req && !sr_req && !sr_pend_q && !refresh_due)
               state_d = ST_PD_HOLD;
         end
         ST_SR_ENTER:     state_d = ST_SR_HOLD;
         ST_SR_HOLD:      if (wake_req) state_d = ST_SR_EXIT_WAIT;
         ST_SR_EXIT_WAIT: if (tmr_zero) state_d = ST_IDLE;
         ST_PD_HOLD:      if (pd_leave) state_d = ST_PD_EXIT_WAIT;
         ST_PD_EXIT_WAIT: if (tmr_zero) state_d = ST_IDLE;
         default:         state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sr_pend_q   <= 1'b0;
         pd_forced_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_IDLE || state_d == ST_SR_ENTER)
            sr_pend_q <= 1'b0;
         else if (sr_req)
            sr_pend_q <= 1'b1;
         if (state_q == ST_PD_HOLD && pd_leave)
            pd_forced_q <= refresh_due || wd_expire;
      end
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = TW'(SRX - 1);
      if (state_q == ST_SR_HOLD && wake_req) begin
         tmr_load = 1'b1;
         tmr_val  = TW'(SRX - 1);
      end else if (state_q == ST_PD_HOLD && pd_leave) begin
         tmr_load = 1'b1;
         tmr_val  = TW'(T_PDX - 1);
      end
   end

   lp_down_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   lp_pd_watchdog #(.LIMIT(PD_MAX)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state_q == ST_PD_HOLD),
      .expire (wd_expire)
   );

   lp_pin_drive u_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state_q),
      .cke   (cke),
      .cmd   (cmd),
      .ready (ready)
   );

   generate
      if (BURST_REFRESH) begin : g_sr_burst
         assign sr_kick = (state_q == ST_SR_EXIT_WAIT) && tmr_zero;
      end else begin : g_sr_spread
         assign sr_kick = 1'b0;
      end
   endgenerate

   assign pd_kick  = (state_q == ST_PD_EXIT_WAIT) && tmr_zero && pd_forced_q;
   assign rfsh_req = sr_kick || pd_kick;

   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;

   // R3
   sref_banks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SR_ENTER) |-> $past(banks_idle));

   // R6
   kick_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_req |=> ready);

   // R4
   sr_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SR_HOLD && !wake_req) |=> (!cke && !ready));

   // R7
   pd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && refresh_due) |=> state_q != ST_PD_HOLD);

endmodule

// File: tb/sim_sdram_lp_seq.sv
module sim_sdram_lp_seq;
   localparam int T_RC   = 3;
   localparam int T_XSR  = 2;
   localparam int T_PDX  = 2;
   localparam int PD_MAX = 6;
   localparam int SRX    = T_RC + T_XSR;
   localparam logic [3:0] NOP  = 4'b0111;
   localparam logic [3:0] SREF = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sr_req = 0, pd_req = 0, wake_req = 0, banks_idle = 1, refresh_due = 0;
   logic cke, cs_n, ras_n, cas_n, we_n, ready, rfsh_req;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdram_lp_seq #(
      .T_RC(T_RC), .T_XSR(T_XSR), .T_PDX(T_PDX),
      .PD_MAX(PD_MAX), .BURST_REFRESH(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
      .wake_req(wake_req), .banks_idle(banks_idle), .refresh_due(refresh_due),
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ready(ready), .rfsh_req(rfsh_req)
   );

   task automatic chk(input string req, input logic e_rdy, input logic e_cke,
                      input logic [3:0] e_cmd, input logic e_rf);
      logic [6:0] act, exp;
      act = {ready, cke, cs_n, ras_n, cas_n, we_n, rfsh_req};
      exp = {e_rdy, e_cke, e_cmd, e_rf};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t {ready,cke,cmd,rfsh} actual=%b expected=%b",
                  req, $time, act, exp);
      end
   endtask

   task automatic run_sr(input int d, input int h);
      banks_idle = (d == 0);
      sr_req = 1;
      @(negedge clk);
      sr_req = 0;
      for (int i = 0; i < d; i++) begin
         chk("R3 pending", 1, 1, NOP, 0);
         pd_req = (i == 0 && d >= 2);
         if (i == d - 1) banks_idle = 1;
         @(negedge clk);
         pd_req = 0;
      end
      chk("R2 sref cmd", 0, 0, SREF, 0);
      @(negedge clk);
      for (int j = 0; j < h; j++) begin
         chk("R4 sr hold", 0, 0, NOP, 0);
         pd_req = (j == 0);
         refresh_due = (j == 1);
         sr_req = (j == 2);
         wake_req = (j == h - 1);
         @(negedge clk);
         pd_req = 0; refresh_due = 0; sr_req = 0; wake_req = 0;
      end
      for (int k = 0; k < SRX; k++) begin
         chk((k == SRX - 1) ? "R6 burst kick" : "R5 sr exit nop", 0, 1, NOP, (k == SRX - 1));
         @(negedge clk);
      end
      chk("R5 ready after sr", 1, 1, NOP, 0);
   endtask

   // cause: 0 wake, 1 refresh_due, 2 watchdog
   task automatic run_pd(input int h, input int cause);
      int n;
      logic forced;
      n = (cause == 2) ? PD_MAX : h;
      forced = (cause != 0) || (n == PD_MAX);
      pd_req = 1;
      @(negedge clk);
      pd_req = 0;
      for (int j = 0; j < n; j++) begin
         chk((j == 0) ? "R7 pd entry" : "R8 pd hold", 0, 0, NOP, 0);
         if (j == n - 1 && cause == 0) wake_req = 1;
         if (j == n - 1 && cause == 1) refresh_due = 1;
         @(negedge clk);
         wake_req = 0; refresh_due = 0;
      end
      for (int k = 0; k < T_PDX; k++) begin
         chk((k == T_PDX - 1) ? "R10 pd kick" : "R9 pd exit nop", 0, 1, NOP,
             (k == T_PDX - 1) && forced);
         @(negedge clk);
      end
      chk("R9 ready after pd", 1, 1, NOP, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 1, 1, NOP, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset", 1, 1, NOP, 0);

      wake_req = 1;
      @(negedge clk);
      wake_req = 0;
      chk("R11 wake in idle", 1, 1, NOP, 0);

      refresh_due = 1; pd_req = 1;
      @(negedge clk);
      refresh_due = 0; pd_req = 0;
      chk("R7 blocked by refresh_due", 1, 1, NOP, 0);
      @(negedge clk);
      chk("R7 still idle", 1, 1, NOP, 0);

      for (int d = 0; d <= 3; d++)
         for (int h = 1; h <= 4; h++) begin
            run_sr(d, h);
            @(negedge clk);
         end

      for (int c = 0; c <= 1; c++)
         for (int h = 1; h <= PD_MAX; h++) begin
            run_pd(h, c);
            @(negedge clk);
         end
      run_pd(0, 2);
      @(negedge clk);
      run_pd(1, 2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule